// File: doc/BRIEF.md
# Register Window Address Decoder

This block decides whether a memory request falls inside the 128 KB window that maps a switch's internal register file. The window is placed by a pair of base registers. The low base register sets address bits 31:17 of the window. The high base register sets address bits 63:32, so the window can sit anywhere in a 64-bit memory space. Decoding works only while a memory-enable bit in a command register is set. All three registers are written and read through a simple configuration port.

The window is cut into fixed 4 KB pages, one per switch port. For each request that hits, the block reports which port's page was selected and the byte offset inside that page. A request entering on any port is decoded the same way. The ingress port does not matter once the base is programmed.

Top module: `bar_window_decoder`

## Requirements
- R1: After reset, the command register and the high base register read 0, and the low base register reads 0x0000_0004. No request hits until software programs the registers.
- R2: The low base register is at configuration offset 0x10. Bits 31:17 are writable. Bits 16:0 always read 0x00004, which marks the base as 64-bit memory and makes the window 128 KB, whatever value is written.
- R3: The high base register is at configuration offset 0x14. All 32 bits are writable and read back exactly as written.
- R4: The command register is at configuration offset 0x04. Only bit 1 (memory enable) is stored, so writing 0xFFFF_FFFF reads back 0x0000_0002.
- R5: While memory enable is 0, no request hits, even one whose address lies inside the programmed window.
- R6: A request hits when memory enable is 1, address bits 63:32 equal the high base register, and address bits 31:17 equal bits 31:17 of the low base register.
- R7: On a hit, `rspPort` equals address bits 16:12 and `rspOffset` equals address bits 11:0. On a miss, both are 0.
- R8: When the high base register is 0, a request whose address bits 63:32 are not 0 misses.
- R9: Each request gives a result in the next cycle: `rspValid` is high exactly one cycle after `reqValid`, and `rspHit` is high only when `rspValid` is high.
- R10: A configuration write to any offset other than 0x04, 0x10 or 0x14 changes no register, and a read of such an offset returns 0.
- R11: The last byte of the window hits port 31 at offset 0xFFF. The byte just above the window misses, and so does the byte just below its base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration byte offset for both reads and writes |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Configuration read data for cfgAddr, combinational |
| reqValid | input | 1 | Memory request strobe |
| reqAddr | input | 64 | Memory request address |
| rspValid | output | 1 | Decode result valid, one cycle after reqValid |
| rspHit | output | 1 | Request hit the register window |
| rspPort | output | 5 | Selected port page |
| rspOffset | output | 12 | Byte offset inside the page |

## Verification
The bench builds the block with its default parameters: a 17-bit window offset and 12-bit pages, which gives 32 port pages of 4 KB. With these values it can reach the first and last pages, both window edges, and the bytes just outside them. The base is placed once with the high base register at 0 and once at a non-zero value, so both the upper-half compare and the zero-upper rule are exercised.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int CFG_AW = 8;
  localparam logic [CFG_AW-1:0] CMD_OFF  = 8'h04;
  localparam logic [CFG_AW-1:0] BASE_LO_OFF = 8'h10;
  localparam logic [CFG_AW-1:0] BASE_HI_OFF = 8'h14;
  localparam int MEM_EN_BIT = 1;
  localparam logic [2:0] MEM64_TYPE = 3'b100;

  typedef enum logic [1:0] {
    SEL_NONE, SEL_CMD, SEL_BASE_LO, SEL_BASE_HI
  } cfgSel_e;

  typedef struct packed {
    logic    wrCmd;
    logic    wrBaseLo;
    logic    wrBaseHi;
    cfgSel_e rdSel;
  } cfgStrobe_t;
endpackage

// File: rtl/bwd_cfg_ctrl.sv
module bwd_cfg_ctrl
  import bwd_pkg::*;
(
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  output cfgStrobe_t        strobe
);
  always_comb begin
    strobe = '{wrCmd: 1'b0, wrBaseLo: 1'b0, wrBaseHi: 1'b0, rdSel: SEL_NONE};
    unique case (cfgAddr)
      CMD_OFF: begin
        strobe.rdSel = SEL_CMD;
        strobe.wrCmd = cfgWrEn;
      end
      BASE_LO_OFF: begin
        strobe.rdSel    = SEL_BASE_LO;
        strobe.wrBaseLo = cfgWrEn;
      end
      BASE_HI_OFF: begin
        strobe.rdSel    = SEL_BASE_HI;
        strobe.wrBaseHi = cfgWrEn;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bwd_datapath.sv
module bwd_datapath
  import bwd_pkg::*;
#(
  parameter int WIN_BITS   = 17,
  parameter int SLICE_BITS = 12
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  cfgStrobe_t                     strobe,
  input  logic [31:0]                    cfgWrData,
  output logic [31:0]                    cfgRdData,
  input  logic                           reqValid,
  input  logic [63:0]                    reqAddr,
  output logic                           rspValid,
  output logic                           rspHit,
  output logic [WIN_BITS-SLICE_BITS-1:0] rspPort,
  output logic [SLICE_BITS-1:0]          rspOffset
);
  localparam int PORT_W = WIN_BITS - SLICE_BITS;
  localparam int BASE_W = 32 - WIN_BITS;
  localparam int PAD_W  = WIN_BITS - 3;

  logic              memEn;
  logic [BASE_W-1:0] baseLo;
  logic [31:0]       baseHi;
  logic              windowMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memEn  <= 1'b0;
      baseLo <= '0;
      baseHi <= '0;
    end else begin
      if (strobe.wrCmd)    memEn  <= cfgWrData[MEM_EN_BIT];
      if (strobe.wrBaseLo) baseLo <= cfgWrData[31:WIN_BITS];
      if (strobe.wrBaseHi) baseHi <= cfgWrData;
    end
  end

  assign windowMatch = memEn
                    && (reqAddr[63:32] == baseHi)
                    && (reqAddr[31:WIN_BITS] == baseLo);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspHit    <= 1'b0;
      rspPort   <= '0;
      rspOffset <= '0;
    end else begin
      rspValid <= reqValid;
      rspHit   <= reqValid && windowMatch;
      if (reqValid && windowMatch) begin
        rspPort   <= reqAddr[WIN_BITS-1:SLICE_BITS];
        rspOffset <= reqAddr[SLICE_BITS-1:0];
      end else begin
        rspPort   <= '0;
        rspOffset <= '0;
      end
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_CMD:     cfgRdData = 32'(memEn) << MEM_EN_BIT;
      SEL_BASE_LO: cfgRdData = {baseLo, {PAD_W{1'b0}}, MEM64_TYPE};
      SEL_BASE_HI: cfgRdData = baseHi;
      default:     cfgRdData = '0;
    endcase
  end
endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
  import bwd_pkg::*;
#(
  parameter int WIN_BITS   = 17,
  parameter int SLICE_BITS = 12
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cfgWrEn,
  input  logic [7:0]                     cfgAddr,
  input  logic [31:0]                    cfgWrData,
  output logic [31:0]                    cfgRdData,
  input  logic                           reqValid,
  input  logic [63:0]                    reqAddr,
  output logic                           rspValid,
  output logic                           rspHit,
  output logic [WIN_BITS-SLICE_BITS-1:0] rspPort,
  output logic [SLICE_BITS-1:0]          rspOffset
);
  cfgStrobe_t strobe;

  bwd_cfg_ctrl uCtrl (
    .cfgWrEn (cfgWrEn),
    .cfgAddr (cfgAddr),
    .strobe  (strobe)
  );

  bwd_datapath #(.WIN_BITS(WIN_BITS), .SLICE_BITS(SLICE_BITS)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .reqValid  (reqValid),
    .reqAddr   (reqAddr),
    .rspValid  (rspValid),
    .rspHit    (rspHit),
    .rspPort   (rspPort),
    .rspOffset (rspOffset)
  );
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker
  import bwd_pkg::*;
#(
  parameter int WIN_BITS   = 17,
  parameter int SLICE_BITS = 12
) (
  input logic                           clk,
  input logic                           rstN,
  input logic [7:0]                     cfgAddr,
  input logic [31:0]                    cfgRdData,
  input logic                           reqValid,
  input logic [63:0]                    reqAddr,
  input logic                           rspValid,
  input logic                           rspHit,
  input logic [WIN_BITS-SLICE_BITS-1:0] rspPort,
  input logic [SLICE_BITS-1:0]          rspOffset
);
  p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_valid_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  p_hit_needs_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> rspValid);
  p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    !rspHit |-> (rspPort == '0 && rspOffset == '0));
  p_slice_fields_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> ({rspPort, rspOffset} == $past(reqAddr[WIN_BITS-1:0])));
  p_base_type_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAddr == BASE_LO_OFF) |-> (cfgRdData[WIN_BITS-1:0] == WIN_BITS'(MEM64_TYPE)));
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAddr != CMD_OFF && cfgAddr != BASE_LO_OFF && cfgAddr != BASE_HI_OFF)
      |-> (cfgRdData == 32'h0));
endmodule

bind bar_window_decoder bwd_checker #(.WIN_BITS(WIN_BITS), .SLICE_BITS(SLICE_BITS)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgAddr   (cfgAddr),
  .cfgRdData (cfgRdData),
  .reqValid  (reqValid),
  .reqAddr   (reqAddr),
  .rspValid  (rspValid),
  .rspHit    (rspHit),
  .rspPort   (rspPort),
  .rspOffset (rspOffset)
);

// File: tb/bar_window_decoder_test.sv
`timescale 1ns/1ps
module bar_window_decoder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = 8'h00;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        reqValid = 1'b0;
  logic [63:0] reqAddr = '0;
  logic        rspValid, rspHit;
  logic [4:0]  rspPort;
  logic [11:0] rspOffset;

  int testCount = 0;
  int failCount = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bar_window_decoder uut (.*);

  // {address, expected hit, expected port, expected offset}
  localparam int NVEC = 8;
  localparam logic [81:0] VEC [NVEC] = '{
    {64'h0000_0000_0100_0000, 1'b1, 5'd0,  12'h000},  // R6 base
    {64'h0000_0000_0100_1234, 1'b1, 5'd1,  12'h234},  // R7
    {64'h0000_0000_0101_8ABC, 1'b1, 5'd24, 12'hABC},  // R7
    {64'h0000_0000_0101_FFFF, 1'b1, 5'd31, 12'hFFF},  // R11 last byte
    {64'h0000_0000_0102_0000, 1'b0, 5'd0,  12'h000},  // R11 above
    {64'h0000_0000_00FF_FFFF, 1'b0, 5'd0,  12'h000},  // R11 below
    {64'h0000_0001_0100_0000, 1'b0, 5'd0,  12'h000},  // R8
    {64'h0000_0000_0200_0000, 1'b0, 5'd0,  12'h000}   // R6 other
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgAddr = a; cfgWrData = d; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic cfgRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfgAddr = a;
    #1 d = cfgRdData;
  endtask

  task automatic doReq(input logic [63:0] a);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic checkResp(input string tag, input logic h, input logic [4:0] p, input logic [11:0] o);
    check({tag, " valid"}, 64'(rspValid), 64'd1);
    check({tag, " hit"}, 64'(rspHit), 64'(h));
    check({tag, " port"}, 64'(rspPort), 64'(p));
    check({tag, " offset"}, 64'(rspOffset), 64'(o));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 rspValid", 64'(rspValid), 64'd0);
    check("R1 rspHit", 64'(rspHit), 64'd0);
    cfgRead(8'h04, rd); check("R1 cmd", 64'(rd), 64'h0);
    cfgRead(8'h10, rd); check("R1 baseLo", 64'(rd), 64'h4);
    cfgRead(8'h14, rd); check("R1 baseHi", 64'(rd), 64'h0);
    doReq(64'h0);
    checkResp("R1 no hit", 1'b0, 5'd0, 12'h0);

    // R2 R3 R4 readback masks
    cfgWrite(8'h10, 32'hFFFF_FFFF);
    cfgRead(8'h10, rd); check("R2 baseLo mask", 64'(rd), 64'hFFFE_0004);
    cfgWrite(8'h14, 32'hDEAD_BEEF);
    cfgRead(8'h14, rd); check("R3 baseHi", 64'(rd), 64'hDEAD_BEEF);
    cfgWrite(8'h04, 32'hFFFF_FFFF);
    cfgRead(8'h04, rd); check("R4 cmd", 64'(rd), 64'h2);

    // R10 unmapped offset
    cfgWrite(8'h18, 32'h1234_5678);
    cfgRead(8'h18, rd); check("R10 unmapped read", 64'(rd), 64'h0);
    cfgRead(8'h14, rd); check("R10 baseHi kept", 64'(rd), 64'hDEAD_BEEF);
    cfgRead(8'h10, rd); check("R10 baseLo kept", 64'(rd), 64'hFFFE_0004);

    // program window at 0x0100_0000, disabled first
    cfgWrite(8'h10, 32'h0100_0000);
    cfgWrite(8'h14, 32'h0);
    cfgWrite(8'h04, 32'h0);
    doReq(64'h0000_0000_0100_0040);
    checkResp("R5 disabled", 1'b0, 5'd0, 12'h0);

    cfgWrite(8'h04, 32'h2);
    for (int i = 0; i < NVEC; i++) begin
      doReq(VEC[i][81:18]);
      checkResp($sformatf("R6/R7/R8/R11 vec%0d", i), VEC[i][17], VEC[i][16:12], VEC[i][11:0]);
    end

    // R9 idle cycle yields no response
    @(negedge clk);
    check("R9 idle valid", 64'(rspValid), 64'd0);
    check("R9 idle hit", 64'(rspHit), 64'd0);

    // R6 non-zero high base
    cfgWrite(8'h14, 32'h0000_0002);
    doReq(64'h0000_0002_0100_7040);
    checkResp("R6 high base hit", 1'b1, 5'd7, 12'h040);
    doReq(64'h0000_0000_0100_7040);
    checkResp("R6 high base miss", 1'b0, 5'd0, 12'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule